// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block follows the low-power state of a double-data-rate memory device. It samples the clock-enable input at every rising clock edge and compares it with the level from the previous edge. It combines that pair with the command decoded on the same edge, a flag saying that every bank is precharged, and a flag saying that a read or write burst is still moving data. From these it chooses between running, power-down with all banks precharged, power-down with a row open, and self refresh.

The block drives the input receivers off while the device is powered down or refreshing itself. After a self-refresh exit it holds back reads until a programmable number of clock edges have passed, which models the delay-locked loop settling again. A command sequence that the clock-enable rules forbid raises a one-cycle error pulse. The command decoder, bank state tracking and data path sit around this block and feed it.

Top module: `pwr_ctl`

## Requirements
- R1: In running state (code 0), a clock-enable edge pair high-then-low with all banks idle, no burst busy and command NOP (code 0) moves the state to precharge power-down (code 1) on that edge.
- R2: In running state, a high-then-low pair with all banks idle, no burst busy and command REFRESH (code 6) moves the state to self refresh (code 3).
- R3: In running state, a high-then-low pair with at least one bank open (all_idle low), no burst busy and command NOP moves the state to active power-down (code 2).
- R4: In any of the states 1, 2 or 3, clock enable sampled low on both edges holds the state, and the command inputs are ignored with no error.
- R5: In states 1, 2 or 3, a low-then-high pair returns the state to running on that edge; if the command on that edge is not NOP, the exit still happens and err pulses.
- R6: A self-refresh exit clears read_ok. A READ (code 2) registered at exit edge + k with k below LOCK_CYCLES raises err; from exit edge + LOCK_CYCLES onward read_ok is high and a READ raises no error.
- R7: A high-then-low pair while burst_busy is high raises err and the state stays running.
- R8: In running state, a high-then-low pair with any command other than the legal entry commands, or clock enable low on two edges in a row, raises err and the state stays running.
- R9: inbuf_en is high in running state and low in states 1, 2 and 3.
- R10: Reset (rst_n low, asynchronous) gives state running, inbuf_en high, read_ok high and err low.
- R11: err is registered: it is high in the clock cycle after the offending edge and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable level at this edge |
| cmd | input | 3 | Decoded command: 0 NOP/deselect, 1 activate, 2 read, 3 write, 4 burst stop, 5 precharge, 6 refresh, 7 mode set |
| all_idle | input | 1 | High when every bank is precharged |
| burst_busy | input | 1 | High while a read or write burst is in progress |
| pwr_state | output | 2 | 0 running, 1 precharge power-down, 2 active power-down, 3 self refresh |
| inbuf_en | output | 1 | Enable for the input receivers |
| read_ok | output | 1 | High once the lock wait after self-refresh exit is complete |
| err | output | 1 | One-cycle pulse on an illegal clock-enable or read sequence |

## Verification
Two functions can act on the same edge: the return from self refresh and the read gate. A READ placed on the exit edge must both leave self refresh and count as an error, because the lock counter starts on that edge. The bench provokes the timing edge of the read gate by issuing READs one edge before and exactly on the edge where the lock wait completes. It expects err on the first and none on the second. A clock-enable drop during a busy burst is also judged against an otherwise legal active power-down entry: the state must stay running and err must pulse.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
   typedef enum logic [1:0] {
      PS_RUN      = 2'd0,
      PS_PDN_IDLE = 2'd1,
      PS_PDN_OPEN = 2'd2,
      PS_SELF_REF = 2'd3
   } pwr_state_e;

   localparam int CMD_W = 3;

   localparam logic [CMD_W-1:0] CMD_NOP  = 3'd0;
   localparam logic [CMD_W-1:0] CMD_ACT  = 3'd1;
   localparam logic [CMD_W-1:0] CMD_RD   = 3'd2;
   localparam logic [CMD_W-1:0] CMD_WR   = 3'd3;
   localparam logic [CMD_W-1:0] CMD_BST  = 3'd4;
   localparam logic [CMD_W-1:0] CMD_PRE  = 3'd5;
   localparam logic [CMD_W-1:0] CMD_REF  = 3'd6;
   localparam logic [CMD_W-1:0] CMD_MRS  = 3'd7;
endpackage

// File: rtl/pwr_cke_tracker.sv
module pwr_cke_tracker #(
   parameter bit RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   output logic cke_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_q <= RESET_LEVEL;
      else        cke_q <= cke;
   end
endmodule

// File: rtl/pwr_lock_timer.sv
module pwr_lock_timer #(
   parameter int LOCK_CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic read_ok
);
   localparam int CW = $clog2(LOCK_CYCLES + 1);
   localparam logic [CW-1:0] LOAD_VAL = CW'(LOCK_CYCLES - 1);

   generate
      if (LOCK_CYCLES < 1) begin : g_bad_lock
         $error("pwr_lock_timer: LOCK_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (load)           remain <= LOAD_VAL;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign read_ok = (remain == '0);

   a_r6_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !read_ok || (LOCK_CYCLES == 1));
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
   import pwr_ctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             cke_q,
   input  logic [CMD_W-1:0] cmd,
   input  logic             all_idle,
   input  logic             burst_busy,
   input  logic             read_ok,
   output pwr_state_e       state,
   output logic             err,
   output logic             sref_exit
);
   pwr_state_e nxt;
   logic       err_n;

   wire fall = cke_q && !cke;
   wire rise = !cke_q && cke;
   wire stay_low = !cke_q && !cke;

   always_comb begin
      nxt   = state;
      err_n = 1'b0;
      if (state == PS_RUN) begin
         if (fall) begin
            if (burst_busy)
               err_n = 1'b1;
            else if (cmd == CMD_NOP)
               nxt = all_idle ? PS_PDN_IDLE : PS_PDN_OPEN;
            else if (cmd == CMD_REF && all_idle)
               nxt = PS_SELF_REF;
            else
               err_n = 1'b1;
         end else if (stay_low) begin
            err_n = 1'b1;
         end else if (cmd == CMD_RD && !read_ok) begin
            err_n = 1'b1;
         end
      end else if (rise) begin
         nxt = PS_RUN;
         if (cmd != CMD_NOP) err_n = 1'b1;
      end
   end

   assign sref_exit = (state == PS_SELF_REF) && rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_RUN;
         err   <= 1'b0;
      end else begin
         state <= nxt;
         err   <= err_n;
      end
   end

   a_r1_pdn_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RUN && cke_q && !cke && all_idle && !burst_busy && cmd == CMD_NOP)
      |=> (state == PS_PDN_IDLE && !err));

   a_r2_self_ref_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RUN && cke_q && !cke && all_idle && !burst_busy && cmd == CMD_REF)
      |=> (state == PS_SELF_REF));

   a_r3_pdn_open_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RUN && cke_q && !cke && !all_idle && !burst_busy && cmd == CMD_NOP)
      |=> (state == PS_PDN_OPEN));

   a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PS_RUN && !cke_q && !cke) |=> ($stable(state) && !err));

   a_r5_exit_run: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PS_RUN && !cke_q && cke) |=> (state == PS_RUN));

   a_r5_exit_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PS_RUN && !cke_q && cke && cmd != CMD_NOP) |=> err);

   a_r6_early_read: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RUN && cke_q && cke && cmd == CMD_RD && !read_ok) |=> err);

   a_r7_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RUN && cke_q && !cke && burst_busy) |=> (err && state == PS_RUN));

   a_r8_low_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_RUN && !cke_q && !cke) |=> (err && state == PS_RUN));
endmodule

// File: rtl/pwr_ctl.sv
module pwr_ctl
   import pwr_ctl_pkg::*;
#(
   parameter int LOCK_CYCLES = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke,
   input  logic [2:0] cmd,
   input  logic       all_idle,
   input  logic       burst_busy,
   output logic [1:0] pwr_state,
   output logic       inbuf_en,
   output logic       read_ok,
   output logic       err
);
   logic       cke_q;
   logic       sref_exit;
   pwr_state_e state;

   pwr_cke_tracker #(.RESET_LEVEL(1'b1)) u_cke (
      .clk   (clk),
      .rst_n (rst_n),
      .cke   (cke),
      .cke_q (cke_q)
   );

   pwr_state_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cke        (cke),
      .cke_q      (cke_q),
      .cmd        (cmd),
      .all_idle   (all_idle),
      .burst_busy (burst_busy),
      .read_ok    (read_ok),
      .state      (state),
      .err        (err),
      .sref_exit  (sref_exit)
   );

   pwr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sref_exit),
      .read_ok (read_ok)
   );

   assign pwr_state = state;
   assign inbuf_en  = (state == PS_RUN);

   a_r9_inbuf_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sref_exit) |=> inbuf_en);
endmodule

// File: tb/pwr_ctl_bench.sv
module pwr_ctl_bench;
   localparam int LOCK = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic [2:0] cmd = 3'd0;
   logic       all_idle = 1'b1;
   logic       burst_busy = 1'b0;
   logic [1:0] pwr_state;
   logic       inbuf_en;
   logic       read_ok;
   logic       err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwr_ctl #(.LOCK_CYCLES(LOCK)) u_pwr_ctl (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .all_idle(all_idle),
      .burst_busy(burst_busy), .pwr_state(pwr_state), .inbuf_en(inbuf_en),
      .read_ok(read_ok), .err(err)
   );

   // {cke, cmd[2:0], all_idle, burst_busy, exp_state[1:0], exp_err, exp_inbuf}
   localparam int NV = 13;
   localparam logic [9:0] VEC [NV] = '{
      {1'b1, 3'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},
      {1'b0, 3'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
      {1'b0, 3'd1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
      {1'b1, 3'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},
      {1'b0, 3'd0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0},
      {1'b0, 3'd5, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0},
      {1'b1, 3'd3, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1},
      {1'b1, 3'd0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1},
      {1'b0, 3'd0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1},
      {1'b0, 3'd0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1},
      {1'b1, 3'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},
      {1'b0, 3'd5, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1},
      {1'b1, 3'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1}
   };

   function automatic string vec_tag(input int i);
      case (i)
         1: return "R1";
         2: return "R4";
         3: return "R5";
         4: return "R3";
         5: return "R4";
         6: return "R5";
         8: return "R7";
         9: return "R8";
         11: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic c, input logic [2:0] k, input logic idle, input logic busy);
      cke = c; cmd = k; all_idle = idle; burst_busy = busy;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 5000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", "state", pwr_state, 0);
      check("R10", "inbuf_en", inbuf_en, 1);
      check("R10", "read_ok", read_ok, 1);
      check("R10", "err", err, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][9], VEC[i][8:6], VEC[i][5], VEC[i][4]);
         check(vec_tag(i), "state", pwr_state, int'(VEC[i][3:2]));
         check(vec_tag(i), "err R11", err, int'(VEC[i][1]));
         check("R9", "inbuf_en", inbuf_en, int'(VEC[i][0]));
      end

      // R2: self-refresh entry, hold, exit with lock wait
      step(1'b0, 3'd6, 1'b1, 1'b0);
      check("R2", "state", pwr_state, 3);
      check("R9", "inbuf_en", inbuf_en, 0);
      step(1'b0, 3'd2, 1'b1, 1'b0);
      check("R4", "state", pwr_state, 3);
      check("R4", "err", err, 0);
      step(1'b1, 3'd0, 1'b1, 1'b0);
      check("R5", "state", pwr_state, 0);
      check("R6", "read_ok after exit", read_ok, 0);
      step(1'b1, 3'd2, 1'b1, 1'b0);
      check("R6", "err early read", err, 1);
      for (int k = 2; k <= LOCK - 2; k++) step(1'b1, 3'd0, 1'b1, 1'b0);
      check("R6", "read_ok before end", read_ok, 0);
      step(1'b1, 3'd2, 1'b1, 1'b0);
      check("R6", "err read one edge early", err, 1);
      check("R6", "read_ok at end", read_ok, 1);
      step(1'b1, 3'd2, 1'b1, 1'b0);
      check("R6", "err read on time", err, 0);
      step(1'b1, 3'd0, 1'b1, 1'b0);
      check("R11", "err returns low", err, 0);

      // R5 + R6: exit self refresh with READ on the exit edge
      step(1'b0, 3'd6, 1'b1, 1'b0);
      step(1'b1, 3'd2, 1'b1, 1'b0);
      check("R5", "state after read exit", pwr_state, 0);
      check("R5", "err read on exit", err, 1);
      check("R6", "read_ok", read_ok, 0);

      // R10: asynchronous reset from power-down
      step(1'b1, 3'd0, 1'b1, 1'b0);
      step(1'b0, 3'd0, 1'b1, 1'b0);
      check("R1", "state", pwr_state, 1);
      #2 rst_n = 1'b0;
      #1 check("R10", "state in reset", pwr_state, 0);
      check("R10", "read_ok in reset", read_ok, 1);
      cke = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule